// File: doc/BRIEF.md
# Shadow ROM Banked Memory Mapper

This block sits between a guest CPU's 16-bit memory bus and its memories. It decides, for every bus cycle, whether the access goes to a small boot ROM, to main RAM, or to no memory at all. Three configuration inputs steer the decision: a ROM shadow enable, a 3-bit bank number and a common-area enable. A separate port block owns these inputs and holds them stable.

The decode is combinational. In the cycle the address is presented, the block drives the ROM and RAM enables, the ROM address, the RAM address, the RAM write enable and the RAM write data. Both memories are synchronous. The block therefore registers which source a read used and selects the matching read data one clock later.

The rules are checked in a fixed order:
- While shadowing, the lower 32 KiB is a mirrored 2 KiB boot ROM that ignores writes.
- Otherwise, when the common area is enabled, the top of the map above 0xE000 always reaches RAM.
- Otherwise, any non-zero bank is unpopulated: it reads as 0xFF and drops writes.

Top module: `memMapper`

## Requirements
- R1: With shadowEn high, a read at any address below 0x8000 is served by the ROM: romEn is high and ramEn is low in that cycle.
- R2: romAddr carries busAddr bits 10:0, so a 2 KiB ROM image mirrors across the lower 32 KiB (for example 0x0123 and 0x7923 return the same byte).
- R3: With shadowEn high, a write below 0x8000 is discarded: ramWe, ramEn and romEn all stay low and the RAM contents are unchanged.
- R4: With commonEn high, an address strictly above 0xE000 that is not shadowed goes to RAM at the full address, for reads and writes, whatever bankSel is.
- R5: Priority is shadow first, common area second, bank third: a shadowed address reads ROM even with a non-zero bank, and a common-area address reaches RAM even with a non-zero bank.
- R6: For an address that is neither shadowed nor in the common area, a non-zero bankSel makes a read return 0xFF and drops a write (ramWe low).
- R7: With bankSel equal to 0, an access that is neither shadowed nor in the common area reaches RAM with ramAddr equal to the full 16-bit busAddr.
- R8: Address 0xE000 itself is not in the common area: with commonEn high and a non-zero bank it reads 0xFF.
- R9: ramWe is high only when busWr is high and the access takes the RAM path; reads never raise ramWe.
- R10: busRdata shows the selected read data one clock after busRd is sampled. When no read was sampled on the previous edge, and after reset, busRdata is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 16 | CPU address |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busWdata | input | 8 | CPU write data |
| shadowEn | input | 1 | Boot ROM shadow enable |
| bankSel | input | 3 | Bank number; 0 is the only populated bank |
| commonEn | input | 1 | Common-area enable for addresses above 0xE000 |
| romEn | output | 1 | ROM read enable |
| romAddr | output | 11 | ROM address (busAddr bits 10:0) |
| romRdata | input | 8 | ROM data, one clock after romEn |
| ramEn | output | 1 | RAM enable |
| ramWe | output | 1 | RAM write enable |
| ramAddr | output | 16 | RAM address |
| ramWdata | output | 8 | RAM write data |
| ramRdata | input | 8 | RAM data, one clock after ramEn |
| busRdata | output | 8 | Read data returned to the CPU |

## Verification
The enables, addresses and ramWe are due in the same cycle the bus inputs are applied. The bench drives inputs on a falling edge and checks these strobes one nanosecond later, before the next rising edge. Read data is due one rising edge later, so each read task waits for the following falling edge before comparing busRdata. An idle cycle after a read confirms that the output falls back to 0x00. Dropped writes are confirmed afterwards by reading the same location through the RAM path.

// File: rtl/mapPkg.sv
package mapPkg;

  // Source of the byte returned to the CPU one clock after a read.
  typedef enum logic [1:0] {
    SRC_IDLE = 2'd0,
    SRC_ROM  = 2'd1,
    SRC_RAM  = 2'd2,
    SRC_FILL = 2'd3
  } srcT;

  // Region an address falls in after the priority rules.
  typedef enum logic [1:0] {
    REG_SHADOW = 2'd0,
    REG_COMMON = 2'd1,
    REG_BANK0  = 2'd2,
    REG_EMPTY  = 2'd3
  } regionT;

  // Strobes passed from control to datapath.
  typedef struct packed {
    logic romSel;
    logic ramSel;
    logic ramWr;
    srcT  rdSrc;
  } ctrlT;

endpackage

// File: rtl/mapControl.sv
module mapControl
  import mapPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 3,
  parameter logic [ADDR_W-1:0] SHADOW_TOP  = 16'h8000,
  parameter logic [ADDR_W-1:0] COMMON_BASE = 16'hE000
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic              shadowEn,
  input  logic [BANK_W-1:0] bankSel,
  input  logic              commonEn,
  output ctrlT              ctrl
);

  logic   inShadow;
  logic   inCommon;
  logic   bankOff;
  regionT region;

  assign inShadow = shadowEn && (busAddr < SHADOW_TOP);
  assign inCommon = commonEn && (busAddr > COMMON_BASE);
  assign bankOff  = |bankSel;

  // Priority: shadow, then common area, then bank number.
  always_comb begin
    if (inShadow)      region = REG_SHADOW;
    else if (inCommon) region = REG_COMMON;
    else if (!bankOff) region = REG_BANK0;
    else               region = REG_EMPTY;
  end

  always_comb begin
    ctrl = '{romSel: 1'b0, ramSel: 1'b0, ramWr: 1'b0, rdSrc: SRC_IDLE};
    unique case (region)
      REG_SHADOW: begin
        ctrl.romSel = busRd;
        if (busRd) ctrl.rdSrc = SRC_ROM;
      end
      REG_COMMON, REG_BANK0: begin
        ctrl.ramSel = busRd || busWr;
        ctrl.ramWr  = busWr;
        if (busRd) ctrl.rdSrc = SRC_RAM;
      end
      default: begin
        if (busRd) ctrl.rdSrc = SRC_FILL;
      end
    endcase
  end

endmodule

// File: rtl/mapDatapath.sv
module mapDatapath
  import mapPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int ROM_AW = 11,
  parameter logic [DATA_W-1:0] FILL_BYTE = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlT              ctrl,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] romRdata,
  input  logic [DATA_W-1:0] ramRdata,
  output logic              romEn,
  output logic [ROM_AW-1:0] romAddr,
  output logic              ramEn,
  output logic              ramWe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramWdata,
  output logic [DATA_W-1:0] busRdata
);

  srcT srcQ;

  assign romEn    = ctrl.romSel;
  assign romAddr  = busAddr[ROM_AW-1:0];
  assign ramEn    = ctrl.ramSel;
  assign ramWe    = ctrl.ramSel && ctrl.ramWr;
  assign ramAddr  = busAddr;
  assign ramWdata = busWdata;

  // Remember which source answers the read that the memories see now.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) srcQ <= SRC_IDLE;
    else       srcQ <= ctrl.rdSrc;
  end

  always_comb begin
    unique case (srcQ)
      SRC_ROM:  busRdata = romRdata;
      SRC_RAM:  busRdata = ramRdata;
      SRC_FILL: busRdata = FILL_BYTE;
      default:  busRdata = '0;
    endcase
  end

endmodule

// File: rtl/memMapper.sv
module memMapper
  import mapPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int ROM_AW = 11,
  parameter int BANK_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              shadowEn,
  input  logic [BANK_W-1:0] bankSel,
  input  logic              commonEn,
  output logic              romEn,
  output logic [ROM_AW-1:0] romAddr,
  input  logic [DATA_W-1:0] romRdata,
  output logic              ramEn,
  output logic              ramWe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramWdata,
  input  logic [DATA_W-1:0] ramRdata,
  output logic [DATA_W-1:0] busRdata
);

  localparam logic [ADDR_W-1:0] SHADOW_TOP  = ADDR_W'(1) << (ADDR_W - 1);
  localparam logic [ADDR_W-1:0] COMMON_BASE = ADDR_W'(7) << (ADDR_W - 3);

  ctrlT ctrl;

  mapControl #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W),
    .SHADOW_TOP(SHADOW_TOP), .COMMON_BASE(COMMON_BASE)
  ) uCtrl (
    .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .shadowEn(shadowEn), .bankSel(bankSel), .commonEn(commonEn),
    .ctrl(ctrl)
  );

  mapDatapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROM_AW(ROM_AW), .FILL_BYTE('1)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .busAddr(busAddr), .busWdata(busWdata),
    .romRdata(romRdata), .ramRdata(ramRdata),
    .romEn(romEn), .romAddr(romAddr),
    .ramEn(ramEn), .ramWe(ramWe), .ramAddr(ramAddr), .ramWdata(ramWdata),
    .busRdata(busRdata)
  );

endmodule

// File: rtl/mapChecker.sv
module mapChecker (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] busAddr,
  input logic        busRd,
  input logic        busWr,
  input logic        shadowEn,
  input logic [2:0]  bankSel,
  input logic        commonEn,
  input logic        romEn,
  input logic [10:0] romAddr,
  input logic [7:0]  romRdata,
  input logic        ramEn,
  input logic        ramWe,
  input logic [15:0] ramAddr,
  input logic [7:0]  busRdata
);

  logic lowShadow, topCommon;
  assign lowShadow = shadowEn && (busAddr < 16'h8000);
  assign topCommon = commonEn && (busAddr > 16'hE000);

  p_rom_low_r1: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && lowShadow) |-> (romEn && !ramEn));

  p_rom_mirror_r2: assert property (@(posedge clk) disable iff (!rstN)
    romEn |-> (romAddr == busAddr[10:0]));

  p_shadow_drop_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !busRd && lowShadow) |-> (!ramWe && !ramEn && !romEn));

  p_common_ram_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((busRd || busWr) && !lowShadow && topCommon) |-> (ramEn && ramAddr == busAddr));

  p_empty_fill_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && !lowShadow && !topCommon && bankSel != 3'd0) |=> (busRdata == 8'hFF));

  p_we_strobe_r9: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (busWr && ramEn));

  p_rom_latency_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && romEn) |=> (busRdata == romRdata));

  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |=> (busRdata == 8'h00));

endmodule

bind memMapper mapChecker uChk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
  .shadowEn(shadowEn), .bankSel(bankSel), .commonEn(commonEn),
  .romEn(romEn), .romAddr(romAddr), .romRdata(romRdata),
  .ramEn(ramEn), .ramWe(ramWe), .ramAddr(ramAddr), .busRdata(busRdata)
);

// File: tb/memMapper_test.sv
`timescale 1ns/1ps
module memMapper_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic        busRd = 1'b0, busWr = 1'b0;
  logic [7:0]  busWdata = '0;
  logic        shadowEn = 1'b0, commonEn = 1'b0;
  logic [2:0]  bankSel = '0;
  logic        romEn, ramEn, ramWe;
  logic [10:0] romAddr;
  logic [15:0] ramAddr;
  logic [7:0]  ramWdata, busRdata;
  logic [7:0]  romRdata = '0, ramRdata = '0;

  int checks = 0, fails = 0;
  logic [7:0] ramMem [256];

  always #2 clk = ~clk;

  memMapper uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .shadowEn(shadowEn), .bankSel(bankSel),
    .commonEn(commonEn), .romEn(romEn), .romAddr(romAddr), .romRdata(romRdata),
    .ramEn(ramEn), .ramWe(ramWe), .ramAddr(ramAddr), .ramWdata(ramWdata),
    .ramRdata(ramRdata), .busRdata(busRdata)
  );

  function automatic logic [7:0] romByte(input logic [10:0] a);
    return a[7:0] ^ {5'b0, a[10:8]} ^ 8'hC3;
  endfunction

  function automatic logic [7:0] ramIdx(input logic [15:0] a);
    return {a[15:12], a[3:0]};
  endfunction

  // Synchronous memories seen by the mapper.
  always @(posedge clk) begin
    if (romEn) romRdata <= romByte(romAddr);
    if (ramEn) begin
      if (ramWe) ramMem[ramIdx(ramAddr)] <= ramWdata;
      ramRdata <= ramMem[ramIdx(ramAddr)];
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doRead(input logic [15:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    busAddr = a; busRd = 1'b1; busWr = 1'b0;
    #1 check(!ramWe, "R9 read raised ramWe", ramWe, 0);
    @(negedge clk);
    busRd = 1'b0;
    check(busRdata == exp, tag, busRdata, exp);
  endtask

  task automatic doWrite(input logic [15:0] a, input logic [7:0] d,
                         input bit expWe, input string tag);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1; busRd = 1'b0;
    #1 check(ramWe == expWe, tag, ramWe, expWe);
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic setCfg(input bit sh, input logic [2:0] bk, input bit cm);
    @(negedge clk);
    shadowEn = sh; bankSel = bk; commonEn = cm;
  endtask

  task automatic testReset;
    check(busRdata == 8'h00, "R10 reset busRdata", busRdata, 0);
    check(!romEn && !ramEn && !ramWe, "R10 reset strobes", {romEn, ramEn, ramWe}, 0);
  endtask

  task automatic testShadow;
    setCfg(1, 0, 0);
    @(negedge clk);
    busAddr = 16'h7923; busRd = 1'b1;
    #1 check(romEn && !ramEn, "R1 ROM selected", {romEn, ramEn}, 2);
    check(romAddr == 11'h123, "R2 romAddr mirror", romAddr, 11'h123);
    @(negedge clk);
    busRd = 1'b0;
    check(busRdata == romByte(11'h123), "R10 ROM data latency", busRdata, romByte(11'h123));
    doRead(16'h0123, romByte(11'h123), "R2 mirror low copy");
    doRead(16'h07FF, romByte(11'h7FF), "R1 ROM top byte");
    @(negedge clk);
    check(busRdata == 8'h00, "R10 idle after read", busRdata, 0);
  endtask

  task automatic testShadowWrite;
    setCfg(1, 0, 0);
    doWrite(16'h0400, 8'hAA, 0, "R3 shadow write ramWe");
    setCfg(0, 0, 0);
    doRead(16'h0400, ramMemInit(ramIdx(16'h0400)), "R3 RAM unchanged");
  endtask

  function automatic logic [7:0] ramMemInit(input logic [7:0] i);
    return i ^ 8'h3C;
  endfunction

  task automatic testBank0;
    setCfg(0, 0, 0);
    @(negedge clk);
    busAddr = 16'h1234; busWdata = 8'h5A; busWr = 1'b1;
    #1 check(ramWe && ramAddr == 16'h1234, "R7 bank0 write addr", ramAddr, 16'h1234);
    @(negedge clk);
    busWr = 1'b0;
    doRead(16'h1234, 8'h5A, "R7 bank0 readback");
    doRead(16'h0123, ramMemInit(ramIdx(16'h0123)), "R7 low RAM without shadow");
  endtask

  task automatic testEmptyBank;
    setCfg(0, 3'd3, 0);
    doRead(16'h2005, 8'hFF, "R6 empty bank read");
    doWrite(16'h2005, 8'h11, 0, "R6 empty bank write dropped");
    setCfg(0, 0, 0);
    doRead(16'h2005, ramMemInit(ramIdx(16'h2005)), "R6 RAM unchanged");
  endtask

  task automatic testCommon;
    setCfg(0, 3'd5, 1);
    doWrite(16'hF00F, 8'h77, 1, "R4 common write enabled");
    doRead(16'hF00F, 8'h77, "R4 common readback");
    doRead(16'hE001, ramMemInit(ramIdx(16'hE001)), "R4 just above base");
    doRead(16'hE000, 8'hFF, "R8 base address follows bank");
    setCfg(0, 3'd0, 1);
    doRead(16'hE000, ramMemInit(ramIdx(16'hE000)), "R8 base with bank0");
    setCfg(0, 3'd5, 0);
    doRead(16'hF00F, 8'hFF, "R4 common disabled");
  endtask

  task automatic testPriority;
    setCfg(1, 3'd6, 1);
    doRead(16'h0456, romByte(11'h456), "R5 shadow beats bank");
    doRead(16'hF00F, 8'h77, "R5 common beats bank");
    doRead(16'h9003, 8'hFF, "R5 bank rule last");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) ramMem[i] = ramMemInit(i[7:0]);
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testShadow();
    testShadowWrite();
    testBank0();
    testEmptyBank();
    testCommon();
    testPriority();
    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule